// File: doc/BRIEF.md
# Serial Packet Transmit Framer

This block turns bytes held in a show-ahead transmit FIFO into the bit stream of one radio packet. A one-cycle `start` pulse, given while the block is idle, launches a packet. The block sends at least a selectable number of 0xAA preamble bytes. It goes on sending preamble until the FIFO holds data, then sends a 16-bit sync word, or the same word twice. After the sync word comes the packet body: an optional length byte, an optional address byte, the payload and an optional CRC-16. The body may be whitened with a PN9 sequence. Bits leave one per clock, most significant bit of each byte first, qualified by `bit_valid`.

The payload length comes from one of two places. In variable mode the first byte popped from the FIFO is the length byte. In fixed mode the length is a configuration input. The address byte is not taken from the FIFO. It is inserted from a configuration input. The packet can end in two ways. A normal end pulses `done`. An aborted end pulses `underflow`, which happens when the FIFO runs dry before the payload is complete. All configuration inputs must be held stable while a packet is in progress.

Top module: `pkt_tx_framer`

## Requirements
- R1: While idle, `bit_valid` and `fifo_rd` stay low. A `start` pulse seen at a clock edge while idle makes `bit_valid` high from the next cycle, and the first bit is 1.
- R2: While a packet is sent, one bit is presented per cycle with `bit_valid` high and no gaps. Every byte leaves most significant bit first.
- R3: The minimum number of 0xAA preamble bytes depends on `cfg_pre_sel`. The mapping is: 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→24.
- R4: When the minimum preamble has been sent and the FIFO is empty at a byte boundary, further 0xAA bytes follow. No FIFO byte is popped during this wait.
- R5: The sync word is `cfg_sync_word[15:8]` then `cfg_sync_word[7:0]`. When `cfg_sync_long` is 1, these two bytes are sent twice.
- R6: With `cfg_var_len`=1, the first FIFO byte is sent after the sync word and gives the payload byte count. With `cfg_var_len`=0, no length byte is sent and `cfg_fixed_len` gives the count. A count of 0 means no payload.
- R7: With `cfg_addr_en`=1, `cfg_addr` is sent after the length byte, or directly after the sync word in fixed mode, and before the payload.
- R8: With `cfg_crc_en`=1, two CRC bytes follow the payload, high byte first. The CRC uses polynomial 0x8005 and initial value 0xFFFF. It is computed bit-serially, MSB first, over the length, address and payload bytes before whitening.
- R9: With `cfg_white_en`=1, every bit after the sync word, CRC included, is XORed with bit 0 of a 9-bit register. That register is loaded with all ones after the sync word. After each such bit it shifts right, and its bit 8 takes the old bit 0 XOR the old bit 5. Preamble and sync are never whitened.
- R10: If a payload byte (or the length byte) is needed while `fifo_empty` is high, the packet ends after the current byte. `underflow` then pulses for one cycle and `done` does not pulse.
- R11: A complete packet ends with `done` high for exactly one cycle, in the cycle after the last bit. `fifo_rd` is high only while the FIFO is not empty and only while a packet is in progress. It pops exactly one byte per length or payload byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a packet (honoured when idle) |
| cfg_pre_sel | input | 3 | Minimum preamble length select |
| cfg_sync_long | input | 1 | Send the sync word twice |
| cfg_sync_word | input | 16 | Sync word |
| cfg_var_len | input | 1 | 1: length byte from FIFO, 0: fixed length |
| cfg_fixed_len | input | 8 | Payload byte count in fixed mode |
| cfg_addr_en | input | 1 | Insert the address byte |
| cfg_addr | input | 8 | Address byte value |
| cfg_crc_en | input | 1 | Append CRC-16 |
| cfg_white_en | input | 1 | Whiten the body |
| fifo_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_rd | output | 1 | Pop the head byte at this clock edge |
| bit_out | output | 1 | Serial bit |
| bit_valid | output | 1 | `bit_out` carries a packet bit |
| done | output | 1 | One-cycle pulse: packet complete |
| underflow | output | 1 | One-cycle pulse: packet aborted, FIFO empty |

## Verification
The bench builds the block with its default parameters: preamble byte 0xAA, CRC polynomial 0x8005 with seed 0xFFFF, and a PN9 seed of all ones. These are the values the bench's reference model assumes. The 8-bit length counter and the full preamble select range let the table reach several cases: the longest 24-byte preamble, zero-length payloads, and doubled sync words in both length modes. An underflow is forced in each length mode. A separate test starves the FIFO so that the preamble runs well past its minimum.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;
    localparam int PN_W   = 9;
    localparam int PN_TAP = 5;
    localparam int CNT_W  = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        SEG_IDLE,
        SEG_PRE,
        SEG_SYNC,
        SEG_LEN,
        SEG_ADDR,
        SEG_PAY,
        SEG_CRC
    } seg_e;

    typedef struct packed {
        seg_e              seg;
        logic [BYTE_W-1:0] sh;
        logic [BIT_W-1:0]  bit_idx;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rem;
        logic [CRC_W-1:0]  crc;
        logic [PN_W-1:0]   pn;
        logic              done;
        logic              underflow;
    } fr_state_t;

    // Minimum preamble byte count for each select value.
    function automatic logic [CNT_W-1:0] pre_min_bytes(input logic [2:0] sel);
        case (sel)
            3'd0:    return CNT_W'(2);
            3'd1:    return CNT_W'(3);
            3'd2:    return CNT_W'(4);
            3'd3:    return CNT_W'(6);
            3'd4:    return CNT_W'(8);
            3'd5:    return CNT_W'(12);
            3'd6:    return CNT_W'(16);
            default: return CNT_W'(24);
        endcase
    endfunction
endpackage

// File: rtl/pkt_crc_step.sv
module pkt_crc_step #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   POLY = 16'h8005
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    input  logic         en_i,
    output logic [W-1:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = crc_i[W-1] ^ bit_i;
        crc_o = crc_i;
        if (en_i) begin
            crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end
endmodule

// File: rtl/pkt_pn_step.sv
module pkt_pn_step #(
    parameter int W   = 9,
    parameter int TAP = 5
) (
    input  logic [W-1:0] st_i,
    input  logic         en_i,
    output logic [W-1:0] st_o,
    output logic         mask_o
);
    always_comb begin
        mask_o = st_i[0];
        st_o   = st_i;
        if (en_i) begin
            st_o = {st_i[0] ^ st_i[TAP], st_i[W-1:1]};
        end
    end
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
    import pkt_tx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PRE_BYTE = 8'hAA,
    parameter logic [CRC_W-1:0]  CRC_POLY = 16'h8005,
    parameter logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF,
    parameter logic [PN_W-1:0]   PN_SEED  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cfg_pre_sel,
    input  logic              cfg_sync_long,
    input  logic [15:0]       cfg_sync_word,
    input  logic              cfg_var_len,
    input  logic [7:0]        cfg_fixed_len,
    input  logic              cfg_addr_en,
    input  logic [7:0]        cfg_addr,
    input  logic              cfg_crc_en,
    input  logic              cfg_white_en,
    input  logic [7:0]        fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_rd,
    output logic              bit_out,
    output logic              bit_valid,
    output logic              done,
    output logic              underflow
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] SYNC_HALF = CNT_W'(2);

    fr_state_t q, d;

    logic             in_body, in_cover;
    logic [CRC_W-1:0] crc_upd, crc_now;
    logic [PN_W-1:0]  pn_next;
    logic             pn_mask;
    logic [CNT_W-1:0] pre_n, sync_n;
    logic             to_addr, to_pay, to_crc, finish, abort;

    assign in_cover = (q.seg == SEG_LEN) || (q.seg == SEG_ADDR) || (q.seg == SEG_PAY);
    assign in_body  = in_cover || (q.seg == SEG_CRC);
    assign pre_n    = pre_min_bytes(cfg_pre_sel);
    assign sync_n   = cfg_sync_long ? (SYNC_HALF << 1) : SYNC_HALF;

    pkt_crc_step #(.W(CRC_W), .POLY(CRC_POLY)) i_crc (
        .crc_i (q.crc),
        .bit_i (q.sh[BYTE_W-1]),
        .en_i  (in_cover),
        .crc_o (crc_upd)
    );

    pkt_pn_step #(.W(PN_W), .TAP(PN_TAP)) i_pn (
        .st_i   (q.pn),
        .en_i   (in_body),
        .st_o   (pn_next),
        .mask_o (pn_mask)
    );

    assign bit_out   = q.sh[BYTE_W-1] ^ (in_body & cfg_white_en & pn_mask);
    assign bit_valid = (q.seg != SEG_IDLE);
    assign done      = q.done;
    assign underflow = q.underflow;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.underflow = 1'b0;
        fifo_rd     = 1'b0;
        crc_now     = crc_upd;
        to_addr     = 1'b0;
        to_pay      = 1'b0;
        to_crc      = 1'b0;
        finish      = 1'b0;
        abort       = 1'b0;

        if (q.seg == SEG_IDLE) begin
            if (start) begin
                d.seg     = SEG_PRE;
                d.sh      = PRE_BYTE;
                d.bit_idx = '0;
                d.cnt     = '0;
            end
        end else begin
            d.crc = crc_upd;
            d.pn  = pn_next;
            if (q.bit_idx != LAST_BIT) begin
                d.sh      = q.sh << 1;
                d.bit_idx = q.bit_idx + 1'b1;
            end else begin
                d.bit_idx = '0;
                case (q.seg)
                    SEG_PRE: begin
                        if (({1'b0, q.cnt} + 1'b1 >= {1'b0, pre_n}) && !fifo_empty) begin
                            d.seg = SEG_SYNC;
                            d.cnt = '0;
                            d.sh  = cfg_sync_word[15:8];
                        end else begin
                            d.sh = PRE_BYTE;
                            if (q.cnt != '1) d.cnt = q.cnt + 1'b1;
                        end
                    end
                    SEG_SYNC: begin
                        if (q.cnt + 1'b1 < sync_n) begin
                            d.cnt = q.cnt + 1'b1;
                            d.sh  = q.cnt[0] ? cfg_sync_word[15:8] : cfg_sync_word[7:0];
                        end else begin
                            d.crc   = CRC_INIT;
                            d.pn    = PN_SEED;
                            crc_now = CRC_INIT;
                            if (cfg_var_len) begin
                                if (fifo_empty) begin
                                    abort = 1'b1;
                                end else begin
                                    fifo_rd = 1'b1;
                                    d.seg   = SEG_LEN;
                                    d.sh    = fifo_data;
                                    d.rem   = fifo_data;
                                end
                            end else begin
                                d.rem   = cfg_fixed_len;
                                to_addr = 1'b1;
                            end
                        end
                    end
                    SEG_LEN:  to_addr = 1'b1;
                    SEG_ADDR: to_pay  = 1'b1;
                    SEG_PAY:  to_pay  = 1'b1;
                    SEG_CRC: begin
                        if (q.cnt == '0) begin
                            d.cnt = CNT_W'(1);
                            d.sh  = q.crc[7:0];
                        end else begin
                            finish = 1'b1;
                        end
                    end
                    default: abort = 1'b1;
                endcase

                if (to_addr) begin
                    if (cfg_addr_en) begin
                        d.seg = SEG_ADDR;
                        d.sh  = cfg_addr;
                    end else begin
                        to_pay = 1'b1;
                    end
                end

                if (to_pay) begin
                    if (d.rem == '0) begin
                        to_crc = 1'b1;
                    end else if (fifo_empty) begin
                        abort = 1'b1;
                    end else begin
                        fifo_rd = 1'b1;
                        d.seg   = SEG_PAY;
                        d.sh    = fifo_data;
                        d.rem   = d.rem - 1'b1;
                    end
                end

                if (to_crc) begin
                    if (cfg_crc_en) begin
                        d.seg = SEG_CRC;
                        d.cnt = '0;
                        d.sh  = crc_now[15:8];
                        d.crc = crc_now;
                    end else begin
                        finish = 1'b1;
                    end
                end

                if (finish) begin
                    d.seg  = SEG_IDLE;
                    d.done = 1'b1;
                end
                if (abort) begin
                    d.seg       = SEG_IDLE;
                    d.underflow = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{seg: SEG_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/pkt_tx_framer_chk.sv
module pkt_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic fifo_empty,
    input logic fifo_rd,
    input logic bit_out,
    input logic bit_valid,
    input logic done,
    input logic underflow
);
    // R1
    start_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !bit_valid) |=> (bit_valid && bit_out));

    // R11
    done_after_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bit_valid && $past(bit_valid)));

    // R10
    underflow_after_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (!bit_valid && $past(bit_valid)));

    // R10
    end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && underflow));

    // R11
    pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (!fifo_empty && bit_valid));
endmodule

bind pkt_tx_framer pkt_tx_framer_chk i_chk (.*);

// File: tb/test_pkt_tx_framer.sv
module test_pkt_tx_framer;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] SYNC_W = 16'hD391;
    localparam logic [7:0]  ADDR_B = 8'h5C;

    typedef struct packed {
        logic [2:0] pre_sel;
        logic       sync_long;
        logic       var_len;
        logic       addr_en;
        logic       crc_en;
        logic       white_en;
        logic [7:0] plen;
        logic [7:0] avail;
        logic       exp_under;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd3, 8'd3, 1'b0},
        '{3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd4, 8'd4, 1'b0},
        '{3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd2, 8'd2, 1'b0},
        '{3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd5, 8'd5, 1'b0},
        '{3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd0, 8'd0, 1'b0},
        '{3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd4, 8'd2, 1'b1},
        '{3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd6, 8'd6, 1'b0},
        '{3'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd5, 8'd1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] cfg_pre_sel = '0;
    logic cfg_sync_long = 1'b0, cfg_var_len = 1'b0, cfg_addr_en = 1'b0;
    logic cfg_crc_en = 1'b0, cfg_white_en = 1'b0;
    logic [15:0] cfg_sync_word = SYNC_W;
    logic [7:0] cfg_fixed_len = '0;
    logic [7:0] cfg_addr = ADDR_B;
    logic [7:0] fifo_data;
    logic fifo_empty, fifo_rd, bit_out, bit_valid, done, underflow;

    logic [7:0] fmem [0:63];
    int wr_p = 0;
    int rd_p = 0;
    assign fifo_empty = (rd_p == wr_p);
    assign fifo_data  = fmem[rd_p[5:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (fifo_rd) rd_p <= rd_p + 1;

    pkt_tx_framer i_pkt_tx_framer (.*);

    logic got [0:8191];
    int ng = 0, ndone = 0, nund = 0;
    always @(negedge clk) begin
        if (bit_valid) begin
            got[ng % 8192] = bit_out;
            ng++;
        end
        if (done) ndone++;
        if (underflow) nund++;
    end

    int n_cmp = 0, n_bad = 0;
    logic exp_b [0:2047];
    int ne;
    logic [15:0] crc_m;
    logic [8:0]  pn_m;

    function automatic int min_pre(input logic [2:0] s);
        case (s)
            3'd0: return 2;  3'd1: return 3;  3'd2: return 4;  3'd3: return 6;
            3'd4: return 8;  3'd5: return 12; 3'd6: return 16; default: return 24;
        endcase
    endfunction

    function automatic logic [7:0] pay_byte(input int v, input int k);
        return 8'((v * 16 + k * 29 + 7) & 255);
    endfunction

    task automatic m_byte(input logic [7:0] b, input bit body, input bit feed, input bit wht);
        for (int i = 7; i >= 0; i--) begin
            logic raw, fb;
            raw = b[i];
            if (feed) begin
                fb    = crc_m[15] ^ raw;
                crc_m = {crc_m[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
            end
            exp_b[ne] = (body && wht) ? (raw ^ pn_m[0]) : raw;
            if (body) pn_m = {pn_m[0] ^ pn_m[5], pn_m[8:1]};
            ne++;
        end
    endtask

    task automatic build(input int pre_n, input vec_t v, input int vi);
        int body_n;
        logic [15:0] cf;
        ne = 0;
        for (int i = 0; i < pre_n; i++) m_byte(8'hAA, 0, 0, 0);
        for (int r = 0; r < (v.sync_long ? 2 : 1); r++) begin
            m_byte(SYNC_W[15:8], 0, 0, 0);
            m_byte(SYNC_W[7:0], 0, 0, 0);
        end
        crc_m = 16'hFFFF;
        pn_m  = 9'h1FF;
        if (v.var_len) m_byte(v.plen, 1, 1, v.white_en);
        if (v.addr_en) m_byte(ADDR_B, 1, 1, v.white_en);
        body_n = (v.avail < v.plen) ? int'(v.avail) : int'(v.plen);
        for (int k = 0; k < body_n; k++) m_byte(pay_byte(vi, k), 1, 1, v.white_en);
        if (v.avail >= v.plen && v.crc_en) begin
            cf = crc_m;
            m_byte(cf[15:8], 1, 0, v.white_en);
            m_byte(cf[7:0], 1, 0, v.white_en);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        fmem[wr_p[5:0]] = b;
        wr_p = wr_p + 1;
    endtask

    task automatic apply_cfg(input vec_t v);
        cfg_pre_sel   = v.pre_sel;
        cfg_sync_long = v.sync_long;
        cfg_var_len   = v.var_len;
        cfg_addr_en   = v.addr_en;
        cfg_crc_en    = v.crc_en;
        cfg_white_en  = v.white_en;
        cfg_fixed_len = v.plen;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end(input int d0, input int u0);
        int t = 0;
        while (ndone == d0 && nund == u0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic cmp_stream(input int base, input string tag);
        int bad_at = -1;
        n_cmp++;
        if (ng - base != ne) begin
            n_bad++;
            $display("FAIL %s bit count: actual %0d expected %0d", tag, ng - base, ne);
        end else begin
            for (int i = 0; i < ne; i++)
                if (bad_at < 0 && got[(base + i) % 8192] !== exp_b[i]) bad_at = i;
            if (bad_at >= 0) begin
                n_bad++;
                $display("FAIL %s bit %0d: actual %b expected %b", tag, bad_at,
                         got[(base + bad_at) % 8192], exp_b[bad_at]);
            end
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R11: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(bit_valid == 1'b0, "R1 reset bit_valid", int'(bit_valid), 0);
        chk(done == 1'b0 && underflow == 1'b0, "R1 reset end flags", int'(done | underflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fifo_rd == 1'b0, "R1 reset fifo_rd", int'(fifo_rd), 0);

        // Table of packets: R2 R3 R5 R6 R7 R8 R9 R10 R11
        for (int vi = 0; vi < NV; vi++) begin
            vec_t v;
            int base, rd0, d0, u0, body_n;
            v = VECS[vi];
            apply_cfg(v);
            if (v.var_len) push(v.plen);
            for (int k = 0; k < int'(v.avail); k++) push(pay_byte(vi, k));
            base = ng; rd0 = rd_p; d0 = ndone; u0 = nund;
            pulse_start();
            wait_end(d0, u0);
            build(min_pre(v.pre_sel), v, vi);
            cmp_stream(base, $sformatf("vec%0d stream R2 R3 R5 R6 R7 R8 R9", vi));
            chk((ndone - d0) == (v.exp_under ? 0 : 1) && (nund - u0) == (v.exp_under ? 1 : 0),
                $sformatf("vec%0d end pulses R10 R11 done/under", vi),
                (ndone - d0) * 10 + (nund - u0), v.exp_under ? 1 : 10);
            body_n = (v.avail < v.plen) ? int'(v.avail) : int'(v.plen);
            chk((rd_p - rd0) == body_n + (v.var_len ? 1 : 0),
                $sformatf("vec%0d pops R11", vi), rd_p - rd0, body_n + (v.var_len ? 1 : 0));
        end

        // R1: start held low is ignored even with data waiting
        begin
            int rd0, b0;
            push(8'h01);
            rd0 = rd_p; b0 = ng;
            repeat (20) @(negedge clk);
            chk(ng == b0, "R1 idle no bits", ng - b0, 0);
            chk(rd_p == rd0, "R1 idle no pops", rd_p - rd0, 0);
            push(8'h33);
        end

        // R4: preamble extends while the FIFO is empty
        begin
            vec_t v;
            int base, rd0, d0, u0, npre;
            logic [7:0] bb;
            // drain the two bytes left above with a fixed 2-byte packet
            v = '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 8'd2, 1'b0};
            apply_cfg(v);
            d0 = ndone; u0 = nund;
            pulse_start();
            wait_end(d0, u0);
            v = '{3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd1, 8'd1, 1'b0};
            apply_cfg(v);
            base = ng; rd0 = rd_p; d0 = ndone; u0 = nund;
            pulse_start();
            repeat (200) @(negedge clk);
            chk(bit_valid == 1'b1 && rd_p == rd0, "R4 waiting in preamble", rd_p - rd0, 0);
            push(8'd1);
            push(pay_byte(99, 0));
            wait_end(d0, u0);
            npre = 0;
            for (int i = 0; i < 64; i++) begin
                for (int j = 0; j < 8; j++) bb[7-j] = got[(base + i*8 + j) % 8192];
                if (bb == 8'hAA && npre == i) npre++;
            end
            chk(npre >= 25, "R4 extended preamble bytes", npre, 25);
            build(npre, v, 99);
            cmp_stream(base, "R4 R5 stream after extended preamble");
        end

        finish_run();
    end
endmodule